// File: doc/BRIEF.md
# Analog Input Channel Sequencer

This block produces the channel address for the analog multiplexer in front of a data converter. A host programs one sequence register with a first and a last channel address. It then preloads the channel counter by raising a load-select level and writing once to the counter-clear strobe. After that, every conversion-complete pulse moves the counter on by one channel. When the counter reaches the last address, the next pulse returns it to the first address. The sequence register keeps its contents while the counter runs, so a later preload restarts the same scan.

A mode input chooses between two kinds of operation. In single-ended mode the full address picks one of 2^ADDR_W inputs, and channels are visited in ascending order. In differential mode the address MSB is dropped and the low bits pick a pair: input n drives the positive side and input n+half drives the negative side. Both the counting and the last-address comparison use only the low bits in this mode, so a stray MSB written by software does not break the wrap.

The load-select level is tracked by a two-state machine. ST_RUN is the reset state. The transition "arm" (ST_RUN to ST_ARMED) happens when load_sel is sampled high, and it emits a one-cycle pulse on irq_clr. The transition "disarm" (ST_ARMED to ST_RUN) happens when load_sel is sampled low. Every counter-clear write emits a one-cycle pulse on pretrig_rst, which tells neighbouring logic to discard its pre-trigger setup.

Top module: `amux_seq`

## Requirements
- R1: After reset, mux_addr is 0, pos_sel has only bit 0 set, neg_sel is 0, and irq_clr and pretrig_rst are 0.
- R2: A cfg_wr pulse stores cfg_data[3:0] as the first address and cfg_data[7:4] as the last address. Counting never changes these values, so a later preload again yields the same first address.
- R3: When clr_wr is high and load_sel is high at the same edge, mux_addr becomes the first address (masked to 3 bits in differential mode) after that edge.
- R4: When clr_wr is high while load_sel is low, and no conv_done occurs, mux_addr is left unchanged.
- R5: Each conv_done pulse raises mux_addr by exactly one, unless the counter is at the last address.
- R6: A conv_done pulse while the counter equals the last address loads the first address instead of incrementing.
- R7: If the first address is above the last address, the counter rolls over modulo 16 (modulo 8 in differential mode) and continues up to the last address before it returns to the first.
- R8: In differential mode, counting, preload and the last-address comparison use only bits 2..0, and mux_addr bit 3 is 0 after every advance or preload. This holds even when cfg_data bit 3 or bit 7 is set.
- R9: In single-ended mode, pos_sel is one-hot with bit mux_addr set, and neg_sel is all zero.
- R10: In differential mode, pos_sel has only bit mux_addr[2:0] set, and neg_sel has only bit mux_addr[2:0]+8 set.
- R11: irq_clr pulses high for exactly one cycle after the edge where load_sel is first sampled high (the "arm" transition). It stays low while load_sel remains high.
- R12: Every clr_wr pulse, whatever the level of load_sel, produces a one-cycle pulse on pretrig_rst after that edge.
- R13: When a preload and a conv_done fall on the same edge, the preload wins and mux_addr becomes the first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the sequence register |
| cfg_data | input | 8 | Sequence data: [3:0] first address, [7:4] last address |
| load_sel | input | 1 | Load-select level that arms preload |
| clr_wr | input | 1 | Counter-clear write strobe (data ignored) |
| conv_done | input | 1 | One pulse per completed conversion |
| diff_mode | input | 1 | 1 = differential pairs, 0 = single-ended |
| mux_addr | output | 4 | Current channel counter |
| pos_sel | output | 16 | One-hot positive-side input select |
| neg_sel | output | 16 | One-hot negative-side input select (zero in single-ended mode) |
| irq_clr | output | 1 | One-cycle pulse that clears a pending interrupt |
| pretrig_rst | output | 1 | One-cycle pulse that discards pre-trigger setup |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. mux_addr, irq_clr and pretrig_rst each pass through a single register. pos_sel and neg_sel are decoded without a register from mux_addr and the current diff_mode.

The driver applies stimulus on the falling edge. After the following rising edge it pushes the expected values for that edge onto a queue. The monitor pops and compares 1 ns after that same rising edge, while the inputs are still held, so each comparison lands in the cycle the result first appears and before the next stimulus can change the decode.

// File: rtl/amux_seq_pkg.sv
package amux_seq_pkg;

    // Load-select tracking states
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ARMED = 1'b1
    } ls_state_e;

endpackage

// File: rtl/amux_seq_regs.sv
module amux_seq_regs #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2*ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] seq_start,
    output logic [ADDR_W-1:0] seq_end
);

    // Sequence register: written only by the host, never by counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_start <= '0;
            seq_end   <= '0;
        end else if (cfg_wr) begin
            seq_start <= cfg_data[ADDR_W-1:0];
            seq_end   <= cfg_data[2*ADDR_W-1:ADDR_W];
        end
    end

endmodule

// File: rtl/amux_seq_ctrl.sv
module amux_seq_ctrl
    import amux_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_sel,
    input  logic clr_wr,
    output logic preload,
    output logic irq_clr,
    output logic pretrig_rst
);

    ls_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (load_sel)  state_d = ST_ARMED;  // arm
            ST_ARMED: if (!load_sel) state_d = ST_RUN;    // disarm
            default:  state_d = ST_RUN;
        endcase
    end

    // Preload request: a clear write while load-select is high
    assign preload = clr_wr & load_sel;

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_clr     <= 1'b0;
            pretrig_rst <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN:   irq_clr <= load_sel;
                ST_ARMED: irq_clr <= 1'b0;
                default:  irq_clr <= 1'b0;
            endcase
            pretrig_rst <= clr_wr;
        end
    end

endmodule

// File: rtl/amux_seq_count.sv
module amux_seq_count #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              diff_mode,
    input  logic              preload,
    input  logic              advance,
    input  logic [ADDR_W-1:0] seq_start,
    input  logic [ADDR_W-1:0] seq_end,
    output logic [ADDR_W-1:0] cnt
);

    localparam logic [ADDR_W-1:0] FULL_MASK = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] HALF_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] first;
    logic [ADDR_W-1:0] bumped;
    logic              at_last;
    logic [ADDR_W-1:0] cnt_d;

    always_comb begin
        mask    = diff_mode ? HALF_MASK : FULL_MASK;
        cur     = cnt & mask;
        first   = seq_start & mask;
        at_last = (cur == (seq_end & mask));
        bumped  = (cur + 1'b1) & mask;
        if (preload) begin
            cnt_d = first;
        end else if (advance) begin
            cnt_d = at_last ? first : bumped;
        end else begin
            cnt_d = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/amux_seq_decode.sv
module amux_seq_decode #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                  diff_mode,
    input  logic [ADDR_W-1:0]     cnt,
    output logic [2**ADDR_W-1:0]  pos_sel,
    output logic [2**ADDR_W-1:0]  neg_sel
);

    localparam int unsigned NCH  = 2**ADDR_W;
    localparam int unsigned HALF = NCH / 2;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH = ADDR_W'(i);
        if (i < HALF) begin : g_low
            // Low half: single channel or positive side of a pair
            assign pos_sel[i] = diff_mode ? (cnt[ADDR_W-2:0] == CH[ADDR_W-2:0])
                                          : (cnt == CH);
            assign neg_sel[i] = 1'b0;
        end else begin : g_high
            // High half: single channel or negative side of a pair
            assign pos_sel[i] = ~diff_mode & (cnt == CH);
            assign neg_sel[i] = diff_mode & (cnt[ADDR_W-2:0] == CH[ADDR_W-2:0]);
        end
    end

endmodule

// File: rtl/amux_seq.sv
module amux_seq #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [2*ADDR_W-1:0]   cfg_data,
    input  logic                  load_sel,
    input  logic                  clr_wr,
    input  logic                  conv_done,
    input  logic                  diff_mode,
    output logic [ADDR_W-1:0]     mux_addr,
    output logic [2**ADDR_W-1:0]  pos_sel,
    output logic [2**ADDR_W-1:0]  neg_sel,
    output logic                  irq_clr,
    output logic                  pretrig_rst
);

    logic [ADDR_W-1:0] seq_start;
    logic [ADDR_W-1:0] seq_end;
    logic              preload;

    amux_seq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .seq_start (seq_start),
        .seq_end   (seq_end)
    );

    amux_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_sel    (load_sel),
        .clr_wr      (clr_wr),
        .preload     (preload),
        .irq_clr     (irq_clr),
        .pretrig_rst (pretrig_rst)
    );

    amux_seq_count #(.ADDR_W(ADDR_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .diff_mode (diff_mode),
        .preload   (preload),
        .advance   (conv_done),
        .seq_start (seq_start),
        .seq_end   (seq_end),
        .cnt       (mux_addr)
    );

    amux_seq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .diff_mode (diff_mode),
        .cnt       (mux_addr),
        .pos_sel   (pos_sel),
        .neg_sel   (neg_sel)
    );

endmodule

// File: rtl/amux_seq_chk.sv
module amux_seq_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  load_sel,
    input logic                  clr_wr,
    input logic                  conv_done,
    input logic                  diff_mode,
    input logic [ADDR_W-1:0]     seq_start,
    input logic [ADDR_W-1:0]     seq_end,
    input logic [ADDR_W-1:0]     mux_addr,
    input logic [2**ADDR_W-1:0]  pos_sel,
    input logic                  irq_clr,
    input logic                  pretrig_rst
);

    localparam logic [ADDR_W-1:0] FULL_MASK = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] HALF_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [ADDR_W-1:0] m;
    logic [ADDR_W-1:0] st_m;
    logic [ADDR_W-1:0] en_m;
    logic [ADDR_W-1:0] cur_m;
    logic [ADDR_W-1:0] nxt_m;
    logic              loading;

    assign m       = diff_mode ? HALF_MASK : FULL_MASK;
    assign st_m    = seq_start & m;
    assign en_m    = seq_end & m;
    assign cur_m   = mux_addr & m;
    assign nxt_m   = (cur_m + 1'b1) & m;
    assign loading = clr_wr & load_sel;

    // R3
    preload_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> mux_addr == $past(st_m));

    // R4
    ignored_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !load_sel && !conv_done) |=> $stable(mux_addr));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !loading && cur_m != en_m) |=> mux_addr == $past(nxt_m));

    // R6
    wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !loading && cur_m == en_m) |=> mux_addr == $past(st_m));

    // R8
    diff_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_mode && (conv_done || loading)) |=> !mux_addr[ADDR_W-1]);

    // R9
    pos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_sel) == 1);

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_clr);

    // R12
    pretrig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> pretrig_rst);

endmodule

bind amux_seq amux_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_sel    (load_sel),
    .clr_wr      (clr_wr),
    .conv_done   (conv_done),
    .diff_mode   (diff_mode),
    .seq_start   (seq_start),
    .seq_end     (seq_end),
    .mux_addr    (mux_addr),
    .pos_sel     (pos_sel),
    .irq_clr     (irq_clr),
    .pretrig_rst (pretrig_rst)
);

// File: tb/sim_amux_seq.sv
`timescale 1ns/1ps
module sim_amux_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_data = 8'h00;
    logic        load_sel = 1'b0;
    logic        clr_wr = 1'b0;
    logic        conv_done = 1'b0;
    logic        diff_mode = 1'b0;
    logic [3:0]  mux_addr;
    logic [15:0] pos_sel;
    logic [15:0] neg_sel;
    logic        irq_clr;
    logic        pretrig_rst;

    always #2 clk = ~clk;

    amux_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_data    (cfg_data),
        .load_sel    (load_sel),
        .clr_wr      (clr_wr),
        .conv_done   (conv_done),
        .diff_mode   (diff_mode),
        .mux_addr    (mux_addr),
        .pos_sel     (pos_sel),
        .neg_sel     (neg_sel),
        .irq_clr     (irq_clr),
        .pretrig_rst (pretrig_rst)
    );

    typedef struct {
        logic [3:0]  addr;
        logic [15:0] pos;
        logic [15:0] neg;
        logic        irq;
        logic        pre;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference state built from the requirements
    logic [3:0] m_start = 4'h0;
    logic [3:0] m_end   = 4'h0;
    logic [3:0] m_cnt   = 4'h0;
    logic       m_ls    = 1'b0;

    task automatic step(input logic cw, input logic [7:0] cd, input logic ls,
                        input logic cl, input logic cv, input logic dm,
                        input string tag);
        logic [3:0] mk;
        logic [3:0] cur;
        exp_t e;
        @(negedge clk);
        cfg_wr = cw; cfg_data = cd; load_sel = ls;
        clr_wr = cl; conv_done = cv; diff_mode = dm;
        @(posedge clk);
        mk  = dm ? 4'h7 : 4'hF;
        cur = m_cnt & mk;
        if (ls && cl)
            m_cnt = m_start & mk;
        else if (cv)
            m_cnt = (cur == (m_end & mk)) ? (m_start & mk) : ((cur + 4'd1) & mk);
        if (cw) begin
            m_start = cd[3:0];
            m_end   = cd[7:4];
        end
        e.irq  = ls && !m_ls;
        m_ls   = ls;
        e.pre  = cl;
        e.addr = m_cnt;
        if (dm) begin
            e.pos = 16'h1 << m_cnt[2:0];
            e.neg = 16'h1 << (m_cnt[2:0] + 4'd8);
        end else begin
            e.pos = 16'h1 << m_cnt;
            e.neg = 16'h0;
        end
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (mux_addr !== e.addr || pos_sel !== e.pos || neg_sel !== e.neg ||
                irq_clr !== e.irq || pretrig_rst !== e.pre) begin
                errors++;
                $display("FAIL %s: actual addr=%h pos=%h neg=%h irq=%b pre=%b expected addr=%h pos=%h neg=%h irq=%b pre=%b",
                         e.tag, mux_addr, pos_sel, neg_sel, irq_clr, pretrig_rst,
                         e.addr, e.pos, e.neg, e.irq, e.pre);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 8'h00, 0, 0, 0, 0, "R1");
        // R2 program first=2 last=5; R11 arm pulse
        step(1, 8'h52, 1, 0, 0, 0, "R2_R11");
        step(0, 8'h00, 1, 0, 0, 0, "R11_hold");
        // R3 preload, R12 pulse
        step(0, 8'h00, 1, 1, 0, 0, "R3_R12");
        step(0, 8'h00, 0, 0, 0, 0, "R11_disarm");
        // R5 R6 R9 counting and wrap
        for (int i = 0; i < 6; i++) step(0, 8'h00, 0, 0, 1, 0, "R5_R6_R9");
        // R4 ignored clear, R12
        step(0, 8'h00, 0, 1, 0, 0, "R4_R12");
        step(0, 8'h00, 0, 0, 0, 0, "R4_idle");
        // R7 first=14 last=2
        step(1, 8'h2E, 0, 0, 0, 0, "R2_cfg");
        step(0, 8'h00, 1, 1, 0, 0, "R3_R7");
        step(0, 8'h00, 0, 0, 0, 0, "R7_idle");
        for (int i = 0; i < 6; i++) step(0, 8'h00, 0, 0, 1, 0, "R7");
        // R8 R10 differential, bits 3 and 7 set: first=9 last=11
        step(1, 8'hB9, 0, 0, 0, 1, "R10_cfg");
        step(0, 8'h00, 1, 1, 0, 1, "R8_R3");
        step(0, 8'h00, 0, 0, 0, 1, "R8_idle");
        for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 0, 1, 1, "R8_R10");
        // R7 in differential mode: first=6 last=1
        step(1, 8'h16, 1, 1, 0, 1, "R8_cfg_load");
        step(0, 8'h00, 1, 1, 0, 1, "R8_reload");
        step(0, 8'h00, 0, 0, 0, 1, "R8_idle2");
        for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 0, 1, 1, "R7_R8");
        // R13 preload wins over conv_done
        step(0, 8'h00, 1, 1, 1, 1, "R13");
        step(0, 8'h00, 0, 0, 1, 1, "R13_next");
        // R2 register kept after counting: single-ended reload
        step(0, 8'h00, 1, 1, 1, 0, "R2_keep");
        step(0, 8'h00, 0, 0, 1, 0, "R9_step");
        step(0, 8'h00, 0, 0, 0, 0, "R9_idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule